// File: doc/BRIEF.md
# Device I/O Access Trap Monitor

This block sits beside an I/O bus and inspects every bus cycle, whether a read or a write. Each cycle is described by an address, a direction strobe and a one-clock valid pulse. The block compares the address against a table of address windows. Each window belongs to one of ten monitored devices. Some windows are fixed legacy ranges. Some are picked from a small configuration code. Two are fully programmable as a base plus a low-order mask.

Every device has one enable bit in a 32-bit control word and one sticky flag in a 32-bit status word. A device can own several windows, and all of them feed that one enable and that one flag. When a cycle lands in an armed window, the block does two things. It raises the device's flag, which stays set until software writes a one to it. It also emits a one-clock request to the system-management interrupt logic.

The configuration inputs are the control word, a window-enable byte, the serial and parallel select codes, and the programmable bases and masks. These are driven by the register file that owns them. The monitor only reads them.

Top module: `iotrap_monitor`

## Requirements
- R1: While reset is asserted and after its release, `dev_sts` reads 0 and `smi_req` is low until a trapped cycle occurs.
- R2: A valid cycle, read or write, that falls in an armed window of device n sets bit (16 + n) of `dev_sts` on the clock edge that samples it. A device with several matching windows gets a single flag.
- R3: A window is armed only when two bits are set: control bit (2n + 1) of `dev_ctrl` for its device n, and the window's own enable. For the configurable windows, that enable is a `cfg_en` bit. The enable bits are: bit 0 serial A, bit 1 serial B, bit 2 parallel, bit 3 programmable A, bit 4 programmable B, bit 5 video, bit 6 keyboard data, bit 7 keyboard command. A hit on an unarmed window changes nothing.
- R4: Devices 0 and 1 (primary disk channel) trap 0x1F0–0x1F7 and 0x3F6. Devices 2 and 3 (secondary disk channel) trap 0x170–0x177 and 0x376. These windows need only their control bit.
- R5: Serial device 4 takes its base from `cfg_ser_sel[2:0]` and serial device 5 from `cfg_ser_sel[5:3]`. The code-to-base map is 0→0x3F8, 1→0x2F8, 2→0x220, 3→0x228, 4→0x238, 5→0x2E8, 6→0x338, 7→0x3E8. Each window is 8 bytes.
- R6: Parallel device 6 uses `cfg_par_sel` to choose a pair of windows. Code 0 gives 0x3BC (4 bytes) and 0x7BC (3 bytes). Code 1 gives 0x378 (8 bytes) and 0x778 (3 bytes). Code 2 gives 0x278 (8 bytes) and 0x678 (3 bytes). Code 3 disarms both windows.
- R7: Programmable devices 7 (A) and 8 (B) each trap the range that starts at their base with the mask bits cleared and runs for mask + 1 bytes.
- R8: Device 9 owns three windows, each with its own enable: video at 0x3B0–0x3DF, keyboard data at 0x60 and keyboard command at 0x64.
- R9: When `sts_clr_we` is high, each one in `sts_clr_mask` clears the matching status bit. A hit and a clear on the same bit in the same cycle leave the bit set. Status bits are otherwise never cleared.
- R10: `smi_req` is high for exactly one clock after each trapped cycle and low after any cycle with no armed hit.
- R11: A change to any configuration input applies to the next bus cycle presented.
- R12: A cycle outside every armed window leaves `dev_sts` unchanged and `smi_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_valid | input | 1 | One-clock pulse marking a bus cycle |
| io_addr | input | 16 | I/O address of the cycle |
| io_write | input | 1 | 1 for a write cycle, 0 for a read; both trap alike |
| dev_ctrl | input | 32 | Device control word; bit 2n+1 enables device n |
| cfg_en | input | 8 | Per-window enables for the configurable windows |
| cfg_ser_sel | input | 6 | Serial base codes: [2:0] device 4, [5:3] device 5 |
| cfg_par_sel | input | 2 | Parallel window-pair select |
| cfg_prg_a_base | input | 16 | Programmable window A base |
| cfg_prg_a_mask | input | 4 | Programmable window A mask |
| cfg_prg_b_base | input | 16 | Programmable window B base |
| cfg_prg_b_mask | input | 4 | Programmable window B mask |
| sts_clr_we | input | 1 | Write strobe for clearing status |
| sts_clr_mask | input | 32 | Ones clear matching status bits |
| dev_sts | output | 32 | Sticky device status; bit 16+n for device n |
| smi_req | output | 1 | One-clock interrupt request per trapped cycle |

## Verification
A window-table fault shows up on the first cycle that touches the affected range. It appears either as a status bit that is missing, or as a status bit set for the wrong device, one clock after the valid pulse. A status-register fault can take several forms: a lost flag, a flag that clears without a write, or a clear that overrides a simultaneous hit. Each of these is visible on `dev_sts` in the very next cycle, because every cycle of the bench is compared. A request-pulse fault appears as `smi_req` held too long or missing in the cycle after the access. Back-to-back accesses and idle gaps expose both cases.

// File: rtl/iotrap_pkg.sv
package iotrap_pkg;
  localparam int ADDR_W   = 16;
  localparam int REG_W    = 32;
  localparam int NUM_DEV  = 10;
  localparam int NUM_WIN  = 17;
  localparam int STS_BASE = 16;
  localparam int DEV_W    = $clog2(NUM_DEV);

  typedef struct packed {
    logic              arm;
    logic [DEV_W-1:0]  dev;
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
  } win_t;

  function automatic win_t mk_win(input logic arm, input logic [DEV_W-1:0] dev,
                                  input logic [ADDR_W-1:0] base,
                                  input logic [ADDR_W-1:0] len);
    win_t w;
    w.arm = arm;
    w.dev = dev;
    w.lo  = base;
    w.hi  = base + len - 1'b1;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] ser_base(input logic [2:0] code);
    logic [ADDR_W-1:0] b;
    case (code)
      3'd0:    b = 16'h03F8;
      3'd1:    b = 16'h02F8;
      3'd2:    b = 16'h0220;
      3'd3:    b = 16'h0228;
      3'd4:    b = 16'h0238;
      3'd5:    b = 16'h02E8;
      3'd6:    b = 16'h0338;
      default: b = 16'h03E8;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/iotrap_win_cfg.sv
module iotrap_win_cfg
  import iotrap_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int RW   = REG_W,
  parameter int NDEV = NUM_DEV,
  parameter int NWIN = NUM_WIN
) (
  input  logic [RW-1:0]     dev_ctrl,
  input  logic [7:0]        cfg_en,
  input  logic [5:0]        ser_sel,
  input  logic [1:0]        par_sel,
  input  logic [AW-1:0]     prg_a_base,
  input  logic [3:0]        prg_a_mask,
  input  logic [AW-1:0]     prg_b_base,
  input  logic [3:0]        prg_b_mask,
  output win_t [NWIN-1:0]   win_o
);
  localparam int DISK_DEVS = 4;

  logic [NDEV-1:0] ctl_en;
  logic [NDEV-1:0] ctl_unused;

  // Device n is enabled by control bit 2n+1; even bits carry no meaning here.
  for (genvar n = 0; n < NDEV; n++) begin : g_ctl
    assign ctl_en[n]     = dev_ctrl[2*n+1];
    assign ctl_unused[n] = dev_ctrl[2*n];
  end

  // Disk channels: two windows per device, channel picked by device index.
  for (genvar d = 0; d < DISK_DEVS; d++) begin : g_disk
    localparam logic [AW-1:0] MAIN = (d < 2) ? 16'h01F0 : 16'h0170;
    localparam logic [AW-1:0] AUX  = (d < 2) ? 16'h03F6 : 16'h0376;
    assign win_o[2*d]   = mk_win(ctl_en[d], DEV_W'(d), MAIN, 16'd8);
    assign win_o[2*d+1] = mk_win(ctl_en[d], DEV_W'(d), AUX,  16'd1);
  end

  always_comb begin
    win_o[8] = mk_win(ctl_en[4] & cfg_en[0], DEV_W'(4), ser_base(ser_sel[2:0]), 16'd8);
    win_o[9] = mk_win(ctl_en[5] & cfg_en[1], DEV_W'(5), ser_base(ser_sel[5:3]), 16'd8);

    case (par_sel)
      2'd0: begin
        win_o[10] = mk_win(ctl_en[6] & cfg_en[2], DEV_W'(6), 16'h03BC, 16'd4);
        win_o[11] = mk_win(ctl_en[6] & cfg_en[2], DEV_W'(6), 16'h07BC, 16'd3);
      end
      2'd1: begin
        win_o[10] = mk_win(ctl_en[6] & cfg_en[2], DEV_W'(6), 16'h0378, 16'd8);
        win_o[11] = mk_win(ctl_en[6] & cfg_en[2], DEV_W'(6), 16'h0778, 16'd3);
      end
      2'd2: begin
        win_o[10] = mk_win(ctl_en[6] & cfg_en[2], DEV_W'(6), 16'h0278, 16'd8);
        win_o[11] = mk_win(ctl_en[6] & cfg_en[2], DEV_W'(6), 16'h0678, 16'd3);
      end
      default: begin
        win_o[10] = mk_win(1'b0, DEV_W'(6), '0, 16'd1);
        win_o[11] = mk_win(1'b0, DEV_W'(6), '0, 16'd1);
      end
    endcase

    win_o[12] = mk_win(ctl_en[7] & cfg_en[3], DEV_W'(7),
                       prg_a_base & ~{{(AW-4){1'b0}}, prg_a_mask},
                       {{(AW-4){1'b0}}, prg_a_mask} + 1'b1);
    win_o[13] = mk_win(ctl_en[8] & cfg_en[4], DEV_W'(8),
                       prg_b_base & ~{{(AW-4){1'b0}}, prg_b_mask},
                       {{(AW-4){1'b0}}, prg_b_mask} + 1'b1);

    win_o[14] = mk_win(ctl_en[9] & cfg_en[5], DEV_W'(9), 16'h03B0, 16'd48);
    win_o[15] = mk_win(ctl_en[9] & cfg_en[6], DEV_W'(9), 16'h0060, 16'd1);
    win_o[16] = mk_win(ctl_en[9] & cfg_en[7], DEV_W'(9), 16'h0064, 16'd1);
  end

  // R6
  always_comb begin
    if (par_sel == 2'b11)
      par_off_chk: assert (!win_o[10].arm && !win_o[11].arm);
  end
endmodule

// File: rtl/iotrap_window.sv
module iotrap_window
  import iotrap_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  win_t          win,
  input  logic          valid,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic above_lo, below_hi;

  always_comb begin
    above_lo = (addr >= win.lo);
    below_hi = (addr <= win.hi);
    hit      = valid & win.arm & above_lo & below_hi;
  end
endmodule

// File: rtl/iotrap_sts.sv
module iotrap_sts #(
  parameter int RW    = 32,
  parameter int NDEV  = 10,
  parameter int SBASE = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_hit,
  input  logic            clr_we,
  input  logic [RW-1:0]   clr_mask,
  output logic [RW-1:0]   sts_o,
  output logic            smi_o
);
  logic [RW-1:0] sts_q, sts_d, set_vec, clr_vec;
  logic          smi_q, smi_d, sts_ce;

  always_comb begin
    set_vec                 = '0;
    set_vec[SBASE +: NDEV]  = dev_hit;
    clr_vec                 = clr_we ? clr_mask : '0;
    sts_ce                  = clr_we | (|dev_hit);
    sts_d                   = (sts_q & ~clr_vec) | set_vec;
    smi_d                   = |dev_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      smi_q <= 1'b0;
    end else begin
      smi_q <= smi_d;
      if (sts_ce) sts_q <= sts_d;
    end
  end

  assign sts_o = sts_q;
  assign smi_o = smi_q;

  // R9
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_hit) |=> ((sts_q[SBASE +: NDEV] & $past(dev_hit)) == $past(dev_hit)));

  // R10
  smi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|dev_hit) |=> !smi_q);
endmodule

// File: rtl/iotrap_monitor.sv
module iotrap_monitor
  import iotrap_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int RW    = REG_W,
  parameter int NDEV  = NUM_DEV,
  parameter int NWIN  = NUM_WIN,
  parameter int SBASE = STS_BASE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_valid,
  input  logic [AW-1:0] io_addr,
  input  logic          io_write,
  input  logic [RW-1:0] dev_ctrl,
  input  logic [7:0]    cfg_en,
  input  logic [5:0]    cfg_ser_sel,
  input  logic [1:0]    cfg_par_sel,
  input  logic [AW-1:0] cfg_prg_a_base,
  input  logic [3:0]    cfg_prg_a_mask,
  input  logic [AW-1:0] cfg_prg_b_base,
  input  logic [3:0]    cfg_prg_b_mask,
  input  logic          sts_clr_we,
  input  logic [RW-1:0] sts_clr_mask,
  output logic [RW-1:0] dev_sts,
  output logic          smi_req
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  win_t [NWIN-1:0]  win_tab;
  logic [NWIN-1:0]  win_hit;
  logic [NDEV-1:0]  dev_hit;
  logic             dir_unused;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n  = rst_pipe[1];
  assign dir_unused = io_write;

  iotrap_win_cfg #(.AW(AW), .RW(RW), .NDEV(NDEV), .NWIN(NWIN)) u_cfg (
    .dev_ctrl   (dev_ctrl),
    .cfg_en     (cfg_en),
    .ser_sel    (cfg_ser_sel),
    .par_sel    (cfg_par_sel),
    .prg_a_base (cfg_prg_a_base),
    .prg_a_mask (cfg_prg_a_mask),
    .prg_b_base (cfg_prg_b_base),
    .prg_b_mask (cfg_prg_b_mask),
    .win_o      (win_tab)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    iotrap_window #(.AW(AW)) u_win (
      .win   (win_tab[w]),
      .valid (io_valid),
      .addr  (io_addr),
      .hit   (win_hit[w])
    );
  end

  // Fold window hits onto their owning devices.
  always_comb begin
    dev_hit = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (win_hit[w] && (int'(win_tab[w].dev) < NDEV))
        dev_hit[win_tab[w].dev] = 1'b1;
    end
  end

  iotrap_sts #(.RW(RW), .NDEV(NDEV), .SBASE(SBASE)) u_sts (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .dev_hit  (dev_hit),
    .clr_we   (sts_clr_we),
    .clr_mask (sts_clr_mask),
    .sts_o    (dev_sts),
    .smi_o    (smi_req)
  );

  // R10
  smi_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !io_valid |=> !smi_req);

  // R3
  ctl_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_valid && (dev_ctrl == '0)) |=> !smi_req);

  // R2
  write_trap_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_valid && io_write && (|dev_hit)) |=> smi_req);
endmodule

// File: tb/iotrap_monitor_bench.sv
module iotrap_monitor_bench;
  localparam int HALF = 10;   // 20-unit period, 50 MHz at 1 ns units

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_valid, io_write;
  logic [15:0] io_addr;
  logic [31:0] dev_ctrl;
  logic [7:0]  cfg_en;
  logic [5:0]  cfg_ser_sel;
  logic [1:0]  cfg_par_sel;
  logic [15:0] cfg_prg_a_base, cfg_prg_b_base;
  logic [3:0]  cfg_prg_a_mask, cfg_prg_b_mask;
  logic        sts_clr_we;
  logic [31:0] sts_clr_mask;
  logic [31:0] dev_sts;
  logic        smi_req;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [31:0] sts;
    logic        smi;
    string       tag;
  } exp_t;
  exp_t        sb_q[$];
  logic [31:0] exp_sts;

  always #HALF clk = ~clk;

  iotrap_monitor u_iotrap_monitor (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_addr(io_addr),
    .io_write(io_write), .dev_ctrl(dev_ctrl), .cfg_en(cfg_en),
    .cfg_ser_sel(cfg_ser_sel), .cfg_par_sel(cfg_par_sel),
    .cfg_prg_a_base(cfg_prg_a_base), .cfg_prg_a_mask(cfg_prg_a_mask),
    .cfg_prg_b_base(cfg_prg_b_base), .cfg_prg_b_mask(cfg_prg_b_mask),
    .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
    .dev_sts(dev_sts), .smi_req(smi_req)
  );

  function automatic bit inr(input logic [15:0] a, input int base, input int len);
    return (int'(a) >= base) && (int'(a) < base + len);
  endfunction

  function automatic int com_base(input logic [2:0] c);
    case (c)
      3'd0: return 'h3F8;
      3'd1: return 'h2F8;
      3'd2: return 'h220;
      3'd3: return 'h228;
      3'd4: return 'h238;
      3'd5: return 'h2E8;
      3'd6: return 'h338;
      default: return 'h3E8;
    endcase
  endfunction

  // Reference model written from the requirement list.
  function automatic logic [9:0] model_hits(input logic [15:0] a);
    logic [9:0] h;
    int lo;
    h = '0;
    h[0] = dev_ctrl[1] && (inr(a, 'h1F0, 8) || inr(a, 'h3F6, 1));
    h[1] = dev_ctrl[3] && (inr(a, 'h1F0, 8) || inr(a, 'h3F6, 1));
    h[2] = dev_ctrl[5] && (inr(a, 'h170, 8) || inr(a, 'h376, 1));
    h[3] = dev_ctrl[7] && (inr(a, 'h170, 8) || inr(a, 'h376, 1));
    h[4] = dev_ctrl[9]  && cfg_en[0] && inr(a, com_base(cfg_ser_sel[2:0]), 8);
    h[5] = dev_ctrl[11] && cfg_en[1] && inr(a, com_base(cfg_ser_sel[5:3]), 8);
    if (dev_ctrl[13] && cfg_en[2]) begin
      case (cfg_par_sel)
        2'd0: h[6] = inr(a, 'h3BC, 4) || inr(a, 'h7BC, 3);
        2'd1: h[6] = inr(a, 'h378, 8) || inr(a, 'h778, 3);
        2'd2: h[6] = inr(a, 'h278, 8) || inr(a, 'h678, 3);
        default: h[6] = 1'b0;
      endcase
    end
    lo   = int'(cfg_prg_a_base) - (int'(cfg_prg_a_base) % (int'(cfg_prg_a_mask) + 1) & 0)
           - (int'(cfg_prg_a_base) & int'(cfg_prg_a_mask));
    h[7] = dev_ctrl[15] && cfg_en[3] && inr(a, lo, int'(cfg_prg_a_mask) + 1);
    lo   = int'(cfg_prg_b_base) - (int'(cfg_prg_b_base) & int'(cfg_prg_b_mask));
    h[8] = dev_ctrl[17] && cfg_en[4] && inr(a, lo, int'(cfg_prg_b_mask) + 1);
    h[9] = dev_ctrl[19] && ((cfg_en[5] && inr(a, 'h3B0, 48)) ||
                            (cfg_en[6] && a == 16'h0060) ||
                            (cfg_en[7] && a == 16'h0064));
    return h;
  endfunction

  // Driver: present one cycle, push its expected result, return after the edge.
  task automatic step(input logic v, input logic [15:0] a, input logic w,
                      input logic cwe, input logic [31:0] cm, input string tag);
    logic [9:0] h;
    exp_t e;
    @(negedge clk);
    io_valid = v; io_addr = a; io_write = w;
    sts_clr_we = cwe; sts_clr_mask = cm;
    h = v ? model_hits(a) : 10'd0;
    exp_sts = (exp_sts & ~(cwe ? cm : 32'd0)) | ({22'd0, h} << 16);
    e.sts = exp_sts; e.smi = |h; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk);
    #2;
  endtask

  task automatic acc(input logic [15:0] a, input string tag);
    step(1'b1, a, 1'b0, 1'b0, 32'd0, tag);
  endtask

  task automatic wacc(input logic [15:0] a, input string tag);
    step(1'b1, a, 1'b1, 1'b0, 32'd0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 16'h0000, 1'b0, 1'b0, 32'd0, tag);
  endtask

  task automatic clr_all(input string tag);
    step(1'b0, 16'h0000, 1'b0, 1'b1, 32'hFFFF_FFFF, tag);
  endtask

  // Monitor: compare the outputs in the high phase after each edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        tests++;
        if (dev_sts !== e.sts || smi_req !== e.smi) begin
          fails++;
          $display("FAIL %s: sts=%h smi=%b expected sts=%h smi=%b",
                   e.tag, dev_sts, smi_req, e.sts, e.smi);
        end
      end
    end
  end

  initial begin
    #(HALF * 2 * 200000);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_valid = 1'b0; io_addr = '0; io_write = 1'b0;
    dev_ctrl = 32'h000A_AAAA; cfg_en = 8'hFF;
    cfg_ser_sel = {3'd1, 3'd0}; cfg_par_sel = 2'd1;
    cfg_prg_a_base = 16'h1234; cfg_prg_a_mask = 4'h3;
    cfg_prg_b_base = 16'h0480; cfg_prg_b_mask = 4'hF;
    sts_clr_we = 1'b0; sts_clr_mask = '0; exp_sts = '0;

    repeat (3) @(negedge clk);
    tests++;
    if (dev_sts !== 32'd0 || smi_req !== 1'b0) begin
      fails++;
      $display("FAIL R1: sts=%h smi=%b expected sts=0 smi=0", dev_sts, smi_req);
    end
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    idle("R1 after release");

    // R4: disk channels and their edges
    acc(16'h01F0, "R4 primary base");
    acc(16'h01F7, "R4 primary top");
    clr_all("R9 clear all");
    acc(16'h01F8, "R12 primary+1");
    acc(16'h03F6, "R4 primary aux");
    wacc(16'h0376, "R4 secondary aux write");
    acc(16'h016F, "R12 below secondary");
    acc(16'h0177, "R4 secondary top");
    clr_all("R9 clear all");

    // R3: control bit and window enable gating
    dev_ctrl[1] = 1'b0;
    acc(16'h01F2, "R3 only dev1");
    dev_ctrl[1] = 1'b1;
    clr_all("R9 clear");
    cfg_en[0] = 1'b0;
    acc(16'h03F8, "R3 serial A window off");
    cfg_en[0] = 1'b1;
    dev_ctrl[9] = 1'b0;
    acc(16'h03F8, "R3 serial A ctl off");
    dev_ctrl[9] = 1'b1;

    // R5: every serial code, inside and at both edges
    for (int c = 0; c < 8; c++) begin
      cfg_ser_sel[2:0] = 3'(c);
      acc(16'(com_base(3'(c))), "R5 serial A base");
      acc(16'(com_base(3'(c)) + 7), "R5 serial A top");
      acc(16'(com_base(3'(c)) + 8), "R5 serial A past top");
      clr_all("R9 clear");
    end
    cfg_ser_sel[5:3] = 3'd5;
    acc(16'h02E8, "R5 serial B code 5");
    acc(16'h02F8, "R5 serial B old base");
    clr_all("R9 clear");

    // R6: parallel select codes
    for (int p = 0; p < 4; p++) begin
      cfg_par_sel = 2'(p);
      acc(16'h03BC, "R6 par 3BC");
      acc(16'h07BE, "R6 par 7BE");
      acc(16'h07BF, "R6 par 7BF");
      acc(16'h037F, "R6 par 37F");
      acc(16'h077A, "R6 par 77A");
      acc(16'h0278, "R6 par 278");
      acc(16'h067A, "R6 par 67A");
      clr_all("R9 clear");
    end
    cfg_par_sel = 2'd1;

    // R7: programmable windows
    acc(16'h1230, "R7 prog A low");
    acc(16'h1233, "R7 prog A high");
    acc(16'h1234, "R7 prog A past");
    acc(16'h122F, "R7 prog A below");
    acc(16'h048F, "R7 prog B top");
    clr_all("R9 clear");
    // R11: new mask applies to the very next cycle
    cfg_prg_a_mask = 4'h7;
    acc(16'h1237, "R11 prog A widened");
    cfg_prg_b_base = 16'hFFF5; cfg_prg_b_mask = 4'hF;
    acc(16'hFFFF, "R11 prog B moved to top");
    acc(16'h0480, "R11 prog B old base");
    clr_all("R9 clear");

    // R8: video and keyboard windows
    acc(16'h03B0, "R8 video low");
    acc(16'h03DF, "R8 video high");
    clr_all("R9 clear");
    acc(16'h03E0, "R8 video past");
    acc(16'h0060, "R8 kbd data");
    acc(16'h0064, "R8 kbd cmd");
    clr_all("R9 clear");
    acc(16'h0061, "R8 kbd gap");
    cfg_en[6] = 1'b0;
    acc(16'h0060, "R8 kbd data disabled");
    cfg_en[6] = 1'b1;

    // R9: selective clear and hit-beats-clear
    acc(16'h01F0, "R9 set 16 and 17");
    step(1'b0, 16'h0, 1'b0, 1'b1, 32'h0001_0000, "R9 clear bit 16 only");
    step(1'b1, 16'h01F0, 1'b0, 1'b1, 32'h0003_0000, "R9 hit with clear");
    step(1'b1, 16'h0000, 1'b0, 1'b1, 32'h0000_FFFF, "R9 clear low bits");
    clr_all("R9 clear");

    // R10: back-to-back traps then idle
    wacc(16'h0060, "R10 pulse 1");
    acc(16'h0064, "R10 pulse 2");
    idle("R10 idle low");
    idle("R10 idle stays low");

    // R12: valid low on a trap address
    step(1'b0, 16'h01F0, 1'b0, 1'b0, 32'd0, "R12 no valid");
    acc(16'h8000, "R12 unmapped");
    idle("R12 final");

    repeat (3) @(posedge clk);
    #8;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule